// File: doc/BRIEF.md
# Four-Pixel Absolute-Difference Processing Element

This block is one cell of a systolic array that scores candidate reference blocks against a current block by the sum of absolute differences. A cell keeps one row of the current block, four 8-bit pixels packed into a 32-bit word, in a local register. Software or the array controller writes this register once with a load strobe. The cell then reuses that row for the whole stream of reference rows.

On every clock the cell takes one packed reference row and a running partial score from the previous cell. It forms the four per-pixel absolute differences and sums them in a two-level adder tree. It adds that sum to the incoming score and registers the result for the next cell. The reference row passes on to the next cell through a two-stage register chain, so the score and the reference stay in the skew the array expects. Each absolute difference uses one adder on the current pixel plus the inverted reference pixel. The carry out of that sum then decides whether to add one or to invert the sum. No comparator and no second subtractor are needed.

Top module: `sad_quad_pe`

## Requirements
- R1: While `rst` is high at a rising edge, `psad_o` and `ref_pix_o` become zero after that edge. Reset does not clear the stored current row.
- R2: While `cur_load` is low, changes on `cur_pix_i` do not affect later scores.
- R3: After each rising edge with `rst` low, `psad_o` equals `psad_i` plus the sum over the four lanes of |cur − ref|. Here lane k is bits [8k+7:8k] of the stored current row and of the `ref_pix_i` value present at that edge.
- R4: `ref_pix_o` after an edge equals the `ref_pix_i` value present at the previous edge. The reference therefore appears two clock edges after it is applied, provided neither edge had `rst` high.
- R5: For a lane where the current pixel is greater than the reference pixel, the lane adds current − reference.
- R6: For a lane where the current pixel is less than or equal to the reference pixel, the lane adds reference − current. Equal pixels add zero, so identical rows pass `psad_i` through unchanged.
- R7: The four-lane sum reaches its full range up to 1020 (four times 255) without loss.
- R8: The 12-bit result wraps modulo 4096 when `psad_i` plus the lane sum exceeds 4095.
- R9: At a rising edge with `cur_load` high, the score at that edge uses the previously stored row. `cur_pix_i` is captured at that edge and is used from the next edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cur_load | input | 1 | Write strobe for the stored current row |
| cur_pix_i | input | 32 | Current row to store, four 8-bit pixels |
| ref_pix_i | input | 32 | Reference row for this cycle, four 8-bit pixels |
| psad_i | input | 12 | Partial score from the previous cell |
| ref_pix_o | output | 32 | Reference row forwarded to the next cell after two register stages |
| psad_o | output | 12 | Registered updated partial score |

## Verification
The bench drives lanes where the current pixel is above, equal to and below the reference pixel. A design that misuses the carry select would be off by one, or would return a complement, on one side of that split. Full-scale rows check that the tree keeps 1020 intact. A near-full incoming score checks the modulo-4096 wrap, which a design that saturated or dropped a carry would get wrong. The bench also changes `cur_pix_i` while `cur_load` is low, and it loads a new row in the same cycle as a scoring step. A design that read the input port directly, or the freshly loaded value too early, would report a different score. A reset in the middle of the stream must clear both forwarding stages, or stale reference rows would leak to the next cell.

// File: rtl/sad_pe_pkg.sv
package sad_pe_pkg;
    // Default geometry of one processing element.
    localparam int DEF_PIX_W   = 8;
    localparam int DEF_LANES   = 4;
    localparam int DEF_PSAD_W  = 12;
    localparam int DEF_REF_DLY = 2;

    // Width needed to hold the sum of LANES values of PIX_W bits each.
    function automatic int tree_width(input int pix_w, input int lanes);
        return pix_w + $clog2(lanes);
    endfunction
endpackage

// File: rtl/sad_absdiff.sv
module sad_absdiff #(
    parameter int W = 8
) (
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    output logic [W-1:0] diff_o
);
    logic [W:0]   raw_sum;
    logic         x_gt_y;

    always_comb begin
        // One adder: x plus the inverted y. The carry out means x > y.
        raw_sum = {1'b0, x_i} + {1'b0, ~y_i};
        x_gt_y  = raw_sum[W];
        if (x_gt_y) begin
            diff_o = raw_sum[W-1:0] + W'(1);
        end else begin
            diff_o = ~raw_sum[W-1:0];
        end
    end

    always_comb begin
        if (!$isunknown({x_i, y_i})) begin
            p_absdiff_gt_r5: assert ((x_i <= y_i) || (diff_o == W'(x_i - y_i)));
            p_absdiff_le_r6: assert ((x_i > y_i) || (diff_o == W'(y_i - x_i)));
        end
    end
endmodule

// File: rtl/sad_add_tree.sv
module sad_add_tree #(
    parameter int PIX_W = 8,
    parameter int LANES = 4,
    parameter int SUM_W = PIX_W + $clog2(LANES)
) (
    input  logic [LANES-1:0][PIX_W-1:0] leaf_i,
    output logic [SUM_W-1:0]            sum_o
);
    localparam int NODES = 2 * LANES;
    localparam int MAX_SUM = LANES * ((1 << PIX_W) - 1);

    // Heap layout: node 1 is the root, leaves sit at LANES .. 2*LANES-1.
    logic [SUM_W-1:0] node [NODES];

    assign node[0] = '0;

    for (genvar l = 0; l < LANES; l++) begin : g_leaf
        assign node[LANES + l] = SUM_W'(leaf_i[l]);
    end

    for (genvar n = 1; n < LANES; n++) begin : g_node
        assign node[n] = node[2*n] + node[2*n + 1];
    end

    assign sum_o = node[1];

    always_comb begin
        if (!$isunknown(leaf_i)) begin
            p_tree_bound_r7: assert (32'(sum_o) <= MAX_SUM);
        end
    end
endmodule

// File: rtl/sad_quad_pe.sv
module sad_quad_pe #(
    parameter int PIX_W   = sad_pe_pkg::DEF_PIX_W,
    parameter int LANES   = sad_pe_pkg::DEF_LANES,
    parameter int PSAD_W  = sad_pe_pkg::DEF_PSAD_W,
    parameter int REF_DLY = sad_pe_pkg::DEF_REF_DLY
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cur_load,
    input  logic [LANES*PIX_W-1:0]   cur_pix_i,
    input  logic [LANES*PIX_W-1:0]   ref_pix_i,
    input  logic [PSAD_W-1:0]        psad_i,
    output logic [LANES*PIX_W-1:0]   ref_pix_o,
    output logic [PSAD_W-1:0]        psad_o
);
    localparam int BUS_W = LANES * PIX_W;
    localparam int SUM_W = sad_pe_pkg::tree_width(PIX_W, LANES);

    typedef struct packed {
        logic [PSAD_W-1:0]              psad;
        logic [BUS_W-1:0]               cur;
        logic [REF_DLY-1:0][BUS_W-1:0]  refp;
    } pe_state_t;

    pe_state_t st_d, st_q;

    logic [LANES-1:0][PIX_W-1:0] lane_diff;
    logic [SUM_W-1:0]            lane_sum;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        sad_absdiff #(.W(PIX_W)) u_absdiff (
            .x_i    (st_q.cur[l*PIX_W +: PIX_W]),
            .y_i    (ref_pix_i[l*PIX_W +: PIX_W]),
            .diff_o (lane_diff[l])
        );
    end

    sad_add_tree #(.PIX_W(PIX_W), .LANES(LANES), .SUM_W(SUM_W)) u_tree (
        .leaf_i (lane_diff),
        .sum_o  (lane_sum)
    );

    always_comb begin
        st_d         = st_q;
        st_d.psad    = psad_i + PSAD_W'(lane_sum);
        st_d.refp[0] = ref_pix_i;
        for (int s = 1; s < REF_DLY; s++) begin
            st_d.refp[s] = st_q.refp[s-1];
        end
        if (cur_load) begin
            st_d.cur = cur_pix_i;
        end
        if (rst) begin
            st_d.psad = '0;
            st_d.refp = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign psad_o    = st_q.psad;
    assign ref_pix_o = st_q.refp[REF_DLY-1];

    // Count edges since reset so that no property looks before it.
    logic [1:0] chk_age_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            chk_age_q <= '0;
        end else if (chk_age_q != 2'd3) begin
            chk_age_q <= chk_age_q + 2'd1;
        end
    end

    logic [BUS_W-1:0] cur_q;
    assign cur_q = st_q.cur;

    p_ref_delay_r4: assert property (@(posedge clk) disable iff (rst)
        (chk_age_q >= 2'd2) |-> (ref_pix_o == $past(ref_pix_i, 2)));

    p_pass_equal_r6: assert property (@(posedge clk) disable iff (rst)
        ((chk_age_q >= 2'd1) && ($past(ref_pix_i) == $past(cur_q)))
            |-> (psad_o == $past(psad_i)));

    p_cur_hold_r2: assert property (@(posedge clk) disable iff (rst)
        ((chk_age_q >= 2'd1) && !$past(cur_load)) |-> $stable(cur_q));

    p_cur_load_r9: assert property (@(posedge clk) disable iff (rst)
        ((chk_age_q >= 2'd1) && $past(cur_load)) |-> (cur_q == $past(cur_pix_i)));
endmodule

// File: tb/sad_quad_pe_tb.sv
module sad_quad_pe_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        cur_load;
    logic [31:0] cur_pix_i;
    logic [31:0] ref_pix_i;
    logic [11:0] psad_i;
    logic [31:0] ref_pix_o;
    logic [11:0] psad_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;
    logic [31:0] last_applied = 32'h0;

    always #10 clk = ~clk;

    sad_quad_pe u_dut (
        .clk       (clk),
        .rst       (rst),
        .cur_load  (cur_load),
        .cur_pix_i (cur_pix_i),
        .ref_pix_i (ref_pix_i),
        .psad_i    (psad_i),
        .ref_pix_o (ref_pix_o),
        .psad_o    (psad_o)
    );

    // Stimulus rows: {current row, reference row, incoming score}.
    localparam logic [75:0] VEC [0:7] = '{
        {32'h10203040, 32'h10203040, 12'h000},
        {32'hFF00FF00, 32'h00FF00FF, 12'h005},
        {32'h80808080, 32'h7F817F81, 12'h064},
        {32'h01020304, 32'h04030201, 12'h7FF},
        {32'hA05A3C0F, 32'h5AA00F3C, 12'h00C},
        {32'h00000000, 32'hFFFFFFFF, 12'hFFF},
        {32'hC8641E05, 32'h0A1E64C8, 12'h001},
        {32'h7F7F7F7F, 32'h80808080, 12'h000}
    };

    function automatic logic [11:0] model(input logic [31:0] c, input logic [31:0] r,
                                          input logic [11:0] p);
        int s = int'(p);
        for (int k = 0; k < 4; k++) begin
            int a = int'(c[8*k +: 8]);
            int b = int'(r[8*k +: 8]);
            s += (a > b) ? (a - b) : (b - a);
        end
        return 12'(s % 4096);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One clock step; checks the forwarded reference on every step (R4, R1).
    task automatic step();
        logic        was_rst = rst;
        logic [31:0] applied = rst ? 32'h0 : ref_pix_i;
        @(posedge clk);
        @(negedge clk);
        check("R4 ref forward", ref_pix_o, was_rst ? 32'h0 : last_applied);
        last_applied = applied;
    endtask

    task automatic load_row(input logic [31:0] c);
        cur_load = 1'b1; cur_pix_i = c; psad_i = 12'h0;
        step();
        cur_load = 1'b0; cur_pix_i = ~c;
    endtask

    task automatic score(input string req, input logic [31:0] r, input logic [11:0] p,
                         input logic [11:0] exp);
        ref_pix_i = r; psad_i = p;
        step();
        check(req, 32'(psad_o), 32'(exp));
    endtask

    initial begin
        rst = 1'b1; cur_load = 1'b0;
        cur_pix_i = 32'hDEADBEEF; ref_pix_i = 32'h12345678; psad_i = 12'hABC;
        repeat (3) step();
        check("R1 reset psad", 32'(psad_o), 32'h0);
        check("R1 reset ref", ref_pix_o, 32'h0);
        rst = 1'b0;

        // Table walk: load a row, then score one reference row while the
        // load port carries a different value (R2, R3, R5, R6).
        for (int i = 0; i < 8; i++) begin
            logic [31:0] c = VEC[i][75:44];
            logic [31:0] r = VEC[i][43:12];
            logic [11:0] p = VEC[i][11:0];
            load_row(c);
            score("R3 table score", r, p, model(c, r, p));
        end

        // R5: every lane has current above reference.
        load_row(32'h64646464);
        score("R5 current above", 32'h0A141E28, 12'h000, 12'd300);
        // R6: every lane has current below reference, then identical rows.
        load_row(32'h0A141E28);
        score("R6 current below", 32'h64646464, 12'h000, 12'd300);
        score("R6 equal passthrough", 32'h0A141E28, 12'h123, 12'h123);

        // R7: full-scale lanes both ways.
        load_row(32'hFFFFFFFF);
        score("R7 full scale", 32'h00000000, 12'h000, 12'd1020);
        load_row(32'h00000000);
        score("R7 full scale reversed", 32'hFFFFFFFF, 12'h000, 12'd1020);

        // R8: score wraps modulo 4096.
        score("R8 wrap", 32'hFFFFFFFF, 12'hFFF, 12'd1019);

        // R9: load cycle still scores with the old row.
        load_row(32'hFFFFFFFF);
        cur_load = 1'b1; cur_pix_i = 32'h00000000;
        score("R9 old row on load edge", 32'h00000000, 12'h000, 12'd1020);
        cur_load = 1'b0; cur_pix_i = 32'hFFFFFFFF;
        score("R9 new row after load", 32'h00000000, 12'h000, 12'd0);

        // R2: port changes with load low leave the row untouched.
        cur_pix_i = 32'h55AA55AA;
        score("R2 hold", 32'h00000000, 12'h000, 12'd0);
        score("R2 hold again", 32'h01010101, 12'h000, 12'd4);

        // R1: reset mid-stream clears score and both forwarding stages.
        ref_pix_i = 32'hCAFEF00D; psad_i = 12'h777;
        rst = 1'b1;
        step();
        check("R1 mid reset psad", 32'(psad_o), 32'h0);
        rst = 1'b0;
        score("R1 stored row kept", 32'h01010101, 12'h000, 12'd4);
        score("R4 after reset", 32'h02020202, 12'h000, 12'd8);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule